// File: doc/BRIEF.md
# Flash In-System Programming Register Controller

This block sits between a processor core and that core's own flash memory. Software steers it through a small register window while the part is being programmed in the field. Five register slots hold a 16-bit target address (high and low bytes), a byte to write, and the byte returned by the last read. The fifth slot is a control and status register. Only code fetched from the boot ROM may write it. A control write with the start bit set launches one of four flash operations against a flash array model with fixed latency:

- byte read
- byte program
- page erase
- mass erase

A busy flag covers the whole operation. The sequencer checks each request before it issues it. A page erase must name the first byte of a 64-byte page. A mass erase must be given address zero. Any target outside the array, apart from the option location, is refused. A refused request raises an error flag and does nothing else.

The block also decides where the core starts after reset. A boot-select bit lives in bit 0 of a non-volatile option byte. When that bit is 0, which is its erased value, the core starts in the boot ROM. When the bit is 1, the core starts at flash address 0x0000. The bit is sampled only when the block leaves reset, either from the external reset pin or from a programming-interface exit command. Programming the bit therefore has no effect until the next reset. Reads aimed at address 0xFFFF are redirected to the option location at 0x3FFF.

Top module: `flash_isp_ctrl`

## Requirements
- R1: Register select codes are 0 for address high, 1 for address low, 2 for write data, 3 for read data and 4 for control/status. After reset or an exit command, both address registers read 0x00. After reset, the status read returns busy (bit 7) = 0 and error (bit 6) = 0.
- R2: With the option byte bit 0 at 0 (erased), leaving reset drives run_boot_rom = 1 and reset_pc = 0xF000 once boot_vld is 1.
- R3: With the option byte bit 0 at 1, leaving reset drives run_boot_rom = 0 and reset_pc = 0x0000.
- R4: While boot_vld stays 1, run_boot_rom does not change, even if the option byte is reprogrammed. The new value is picked up only at the next reset or exit command.
- R5: Control writes use bits [1:0] as the operation (00 read, 01 byte program, 10 page erase, 11 mass erase) and bit 2 as start. After a completed read, the read-data register returns the byte last programmed at that address.
- R6: A page erase at an address aligned to 64 bytes clears every byte of that page to 0x00. Bytes outside the page are left unchanged.
- R7: A page erase at an address not aligned to 64 bytes sets the error flag and changes no byte. The next accepted operation clears the error flag.
- R8: A mass erase with a non-zero address sets the error flag and changes nothing. A mass erase at 0x0000 clears every byte and the option byte to 0x00.
- R9: A read at 0xFFFF returns the option byte stored at 0x3FFF. A byte program at 0xFFFF is refused with the error flag set.
- R10: While busy, writes to the address and write-data registers are ignored. The running operation uses the values held at its start.
- R11: A control write with boot_priv = 0 is ignored: no operation starts and busy stays 0.
- R12: Busy reads 1 from the cycle after an accepted start until the flash model completes. A start given while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| exit_cmd | input | 1 | Exit command from the programming interface, acts as a reset of the controller |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| boot_priv | input | 1 | High when the current access is fetched from the boot ROM |
| reg_rdata | output | 8 | Read data of the selected register |
| boot_vld | output | 1 | Boot-source outputs are valid |
| run_boot_rom | output | 1 | Core starts in the boot ROM |
| reset_pc | output | 16 | Reset fetch address |

## Verification
The bench reprograms the option bit while the block is running and checks that the boot source does not change until the reset pin is pulsed. A design that sampled the bit continuously would switch its start address in the middle of a run. It also tries to corrupt a running operation with address, write-data and second-start writes. A design that let these through would program the wrong byte or overwrite a read in progress. Misaligned page erases and non-zero mass-erase addresses are checked against neighbouring bytes and the error bit, which catches a validator that starts the erase anyway. Alias reads at 0xFFFF and control writes from user code are covered to expose a missing remap or a missing privilege check.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_PROG   = 2'b01,
    OP_PERASE = 2'b10,
    OP_MERASE = 2'b11
  } isp_op_e;

  localparam logic [2:0] SEL_ADDR_HI = 3'd0;
  localparam logic [2:0] SEL_ADDR_LO = 3'd1;
  localparam logic [2:0] SEL_WDATA   = 3'd2;
  localparam logic [2:0] SEL_RDATA   = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;

  localparam int CTRL_START_BIT = 2;
endpackage

// File: rtl/isp_regfile.sv
module isp_regfile
  import isp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        we,
  input  logic [2:0]  sel,
  input  logic [7:0]  wdata,
  input  logic        busy,
  input  logic        done,
  input  isp_op_e     op,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] addr_o,
  output logic [7:0]  wbyte_o,
  output logic [7:0]  rbyte_o
);
  logic [7:0] hi_q, hi_d, lo_q, lo_d, wb_q, wb_d, rb_q, rb_d;
  logic       wr_ok;

  assign wr_ok = we && !busy;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    wb_d = wb_q;
    rb_d = rb_q;
    if (clr) begin
      hi_d = 8'h00;
      lo_d = 8'h00;
    end else if (wr_ok) begin
      if (sel == SEL_ADDR_HI) hi_d = wdata;
      if (sel == SEL_ADDR_LO) lo_d = wdata;
    end
    if (wr_ok && sel == SEL_WDATA) wb_d = wdata;
    if (done && op == OP_READ)     rb_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 8'h00;
      lo_q <= 8'h00;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk) begin
    wb_q <= wb_d;
    rb_q <= rb_d;
  end

  assign addr_o  = {hi_q, lo_q};
  assign wbyte_o = wb_q;
  assign rbyte_o = rb_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_o)); // R10
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wbyte_o)); // R10
endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer
  import isp_pkg::*;
#(
  parameter int          MEM_DEPTH  = 256,
  parameter int          PAGE_BYTES = 64,
  parameter logic [15:0] OPT_ADDR   = 16'h3FFF,
  parameter logic [15:0] OPT_ALIAS  = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        we,
  input  logic [2:0]  sel,
  input  logic [2:0]  ctrl_bits,
  input  logic        priv,
  input  logic [15:0] addr_i,
  input  logic        done_i,
  output logic [15:0] phys_o,
  output isp_op_e     op_o,
  output logic        busy_o,
  output logic        err_o,
  output logic        req_o
);
  localparam int          PGW     = $clog2(PAGE_BYTES);
  localparam logic [15:0] DEPTH16 = 16'(MEM_DEPTH);

  isp_op_e     op_q, op_d, start_op;
  logic        busy_q, busy_d, err_q, err_d, req_q, req_d;
  logic        ctrl_wr, start, legal;
  logic [15:0] cand;

  function automatic logic [15:0] remap(input logic [15:0] a, input isp_op_e o);
    return (o == OP_READ && a == OPT_ALIAS) ? OPT_ADDR : a;
  endfunction

  assign ctrl_wr  = we && sel == SEL_CTRL && priv;
  assign start_op = isp_op_e'(ctrl_bits[1:0]);
  assign start    = ctrl_wr && ctrl_bits[CTRL_START_BIT] && !busy_q;
  assign cand     = remap(addr_i, start_op);

  always_comb begin
    unique case (start_op)
      OP_READ, OP_PROG: legal = (cand == OPT_ADDR) || (cand < DEPTH16);
      OP_PERASE:        legal = (cand < DEPTH16) && (cand[PGW-1:0] == '0);
      default:          legal = (cand == 16'h0000);
    endcase
  end

  always_comb begin
    op_d   = op_q;
    busy_d = busy_q;
    err_d  = err_q;
    req_d  = 1'b0;
    if (clr) begin
      op_d   = OP_READ;
      busy_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (done_i) busy_d = 1'b0;
      if (ctrl_wr && !busy_q) op_d = start_op;
      if (start) begin
        err_d  = !legal;
        busy_d = legal;
        req_d  = legal;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_READ;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      op_q   <= op_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      req_q  <= req_d;
    end
  end

  assign phys_o = remap(addr_i, op_q);
  assign op_o   = op_q;
  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign req_o  = req_q;

  AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> busy_q); // R12
  AST_USER_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_CTRL && !priv && !busy_q) |=> !req_q); // R11
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !req_q); // R7
endmodule

// File: rtl/isp_flash_model.sv
module isp_flash_model
  import isp_pkg::*;
#(
  parameter int          MEM_DEPTH  = 256,
  parameter int          PAGE_BYTES = 64,
  parameter int          LATENCY    = 4,
  parameter logic [15:0] OPT_ADDR   = 16'h3FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        req,
  input  isp_op_e     op,
  input  logic [15:0] addr,
  input  logic [7:0]  wbyte,
  output logic        done,
  output logic [7:0]  rbyte,
  output logic [7:0]  opt_byte
);
  localparam int MAW = $clog2(MEM_DEPTH);
  localparam int PGW = $clog2(PAGE_BYTES);
  localparam int CW  = $clog2(LATENCY + 1);

  logic [7:0]    mem [MEM_DEPTH];
  logic [7:0]    opt_q;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [MAW-1:0] idx;
  logic           is_opt;

  assign idx    = addr[MAW-1:0];
  assign is_opt = (addr == OPT_ADDR);
  assign done   = act_q && (cnt_q == '0);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (clr) begin
      act_d = 1'b0;
    end else if (req) begin
      act_d = 1'b1;
      cnt_d = CW'(LATENCY - 1);
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done && !clr) begin
      unique case (op)
        OP_PROG: begin
          if (is_opt) opt_q <= wbyte;
          else        mem[idx] <= wbyte;
        end
        OP_PERASE: begin
          for (int i = 0; i < MEM_DEPTH; i++) begin
            if ((MAW'(i) >> PGW) == (idx >> PGW)) mem[i] <= 8'h00;
          end
        end
        OP_MERASE: begin
          for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'h00;
          opt_q <= 8'h00;
        end
        default: ;
      endcase
    end
  end

  assign rbyte    = is_opt ? opt_q : mem[idx];
  assign opt_byte = opt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !act_q); // R12
endmodule

// File: rtl/isp_boot_sel.sv
module isp_boot_sel #(
  parameter logic [15:0] BOOT_VECTOR = 16'hF000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        opt_bit,
  output logic        vld_o,
  output logic        boot_o,
  output logic [15:0] pc_o
);
  logic pend_q, pend_d, boot_q, boot_d;

  always_comb begin
    pend_d = pend_q;
    boot_d = boot_q;
    if (clr) begin
      pend_d = 1'b1;
    end else if (pend_q) begin
      pend_d = 1'b0;
      boot_d = !opt_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    boot_q <= boot_d;
  end

  assign vld_o  = !pend_q;
  assign boot_o = boot_q;
  assign pc_o   = boot_q ? BOOT_VECTOR : 16'h0000;

  AST_BOOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(vld_o)) |-> $stable(boot_q)); // R4
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import isp_pkg::*;
#(
  parameter int          MEM_DEPTH   = 256,
  parameter int          PAGE_BYTES  = 64,
  parameter int          LATENCY     = 4,
  parameter logic [15:0] OPT_ADDR    = 16'h3FFF,
  parameter logic [15:0] OPT_ALIAS   = 16'hFFFF,
  parameter logic [15:0] BOOT_VECTOR = 16'hF000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exit_cmd,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic        boot_priv,
  output logic [7:0]  reg_rdata,
  output logic        boot_vld,
  output logic        run_boot_rom,
  output logic [15:0] reset_pc
);
  logic [1:0]  rst_sync_q;
  logic        srst_n;
  logic [15:0] addr, phys;
  logic [7:0]  wbyte, rbyte, mem_rbyte, opt_byte;
  logic        busy, err, req, done;
  isp_op_e     op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  isp_regfile i_regs (
    .clk(clk), .rst_n(srst_n), .clr(exit_cmd),
    .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .done(done), .op(op), .mem_rdata(mem_rbyte),
    .addr_o(addr), .wbyte_o(wbyte), .rbyte_o(rbyte)
  );

  isp_sequencer #(
    .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES),
    .OPT_ADDR(OPT_ADDR), .OPT_ALIAS(OPT_ALIAS)
  ) i_seq (
    .clk(clk), .rst_n(srst_n), .clr(exit_cmd),
    .we(reg_we), .sel(reg_sel), .ctrl_bits(reg_wdata[2:0]), .priv(boot_priv),
    .addr_i(addr), .done_i(done),
    .phys_o(phys), .op_o(op), .busy_o(busy), .err_o(err), .req_o(req)
  );

  isp_flash_model #(
    .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES),
    .LATENCY(LATENCY), .OPT_ADDR(OPT_ADDR)
  ) i_flash (
    .clk(clk), .rst_n(srst_n), .clr(exit_cmd),
    .req(req), .op(op), .addr(phys), .wbyte(wbyte),
    .done(done), .rbyte(mem_rbyte), .opt_byte(opt_byte)
  );

  isp_boot_sel #(.BOOT_VECTOR(BOOT_VECTOR)) i_boot (
    .clk(clk), .rst_n(srst_n), .clr(exit_cmd), .opt_bit(opt_byte[0]),
    .vld_o(boot_vld), .boot_o(run_boot_rom), .pc_o(reset_pc)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR_HI: reg_rdata = addr[15:8];
      SEL_ADDR_LO: reg_rdata = addr[7:0];
      SEL_WDATA:   reg_rdata = wbyte;
      SEL_RDATA:   reg_rdata = rbyte;
      SEL_CTRL:    reg_rdata = {busy, err, 4'b0000, op};
      default:     reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: tb/test_flash_isp_ctrl.sv
module test_flash_isp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exit_cmd = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        boot_priv = 1'b1;
  logic [7:0]  reg_rdata;
  logic        boot_vld, run_boot_rom;
  logic [15:0] reset_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_opt;

  localparam logic [2:0] S_HI = 3'd0, S_LO = 3'd1, S_WD = 3'd2, S_RD = 3'd3, S_CT = 3'd4;
  localparam logic [1:0] K_RD = 2'b00, K_PG = 2'b01, K_PE = 2'b10, K_ME = 2'b11;

  always #2 clk = ~clk;

  flash_isp_ctrl i_flash_isp_ctrl (
    .clk(clk), .rst_n(rst_n), .exit_cmd(exit_cmd), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .boot_priv(boot_priv),
    .reg_rdata(reg_rdata), .boot_vld(boot_vld), .run_boot_rom(run_boot_rom),
    .reset_pc(reset_pc)
  );

  function automatic logic [15:0] exp_pc(input logic optv);
    return optv ? 16'h0000 : 16'hF000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input bit p);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d; boot_priv = p;
    @(negedge clk);
    reg_we = 1'b0; boot_priv = 1'b1;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 50; k++) begin
      rd(S_CT, v);
      if (!v[7]) break;
    end
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(S_HI, a[15:8], 1'b1);
    wr(S_LO, a[7:0], 1'b1);
  endtask

  task automatic run_op(input logic [1:0] k, input logic [15:0] a);
    set_addr(a);
    wr(S_CT, {5'b0, 1'b1, k}, 1'b1);
    wait_idle();
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    wr(S_WD, d, 1'b1);
    run_op(K_PG, a);
  endtask

  task automatic rdflash(input logic [15:0] a, output logic [7:0] v);
    run_op(K_RD, a);
    rd(S_RD, v);
  endtask

  task automatic do_exit();
    @(negedge clk); exit_cmd = 1'b1;
    @(negedge clk); exit_cmd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pin_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_boot(input string req);
    check(boot_vld == 1'b1, req, {15'b0, boot_vld}, 16'h1);
    check(run_boot_rom == !exp_opt[0], req, {15'b0, run_boot_rom}, {15'b0, !exp_opt[0]});
    check(reset_pc == exp_pc(exp_opt[0]), req, reset_pc, exp_pc(exp_opt[0]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, st;
    logic [7:0] a8, d8;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    rd(S_HI, v); check(v == 8'h00, "R1 addr hi", {8'h0, v}, 16'h0);
    rd(S_LO, v); check(v == 8'h00, "R1 addr lo", {8'h0, v}, 16'h0);
    rd(S_CT, v); check(v[7:6] == 2'b00, "R1 status", {8'h0, v}, 16'h0);

    // R8 mass erase at zero, then R2 boot from ROM after exit
    run_op(K_ME, 16'h0000);
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    exp_opt = 8'h00;
    rd(S_CT, v); check(v[6] == 1'b0, "R8 mass erase accepted", {8'h0, v}, 16'h0);
    set_addr(16'h1234);
    do_exit();
    check_boot("R2");
    rd(S_HI, v); check(v == 8'h00, "R1 hi after exit", {8'h0, v}, 16'h0);

    // R8 mass erase with non-zero address refused
    prog(16'h0005, 8'h5A); exp_mem[5] = 8'h5A;
    run_op(K_ME, 16'h0001);
    rd(S_CT, v); check(v[6] == 1'b1, "R8 error on bad mass erase", {8'h0, v}, 16'h40);
    rdflash(16'h0005, v); check(v == 8'h5A, "R8 byte kept", {8'h0, v}, 16'h5A);

    // R5 random program / read
    for (int n = 0; n < 24; n++) begin
      a8 = 8'($urandom_range(0, 255)); d8 = 8'($urandom_range(1, 255));
      prog({8'h00, a8}, d8); exp_mem[a8] = d8;
    end
    for (int n = 0; n < 24; n++) begin
      a8 = 8'($urandom_range(0, 255));
      rdflash({8'h00, a8}, v);
      check(v == exp_mem[a8], "R5 readback", {8'h0, v}, {8'h0, exp_mem[a8]});
    end

    // R6 page erase at 0x40
    prog(16'h003F, 8'hA1); exp_mem[8'h3F] = 8'hA1;
    prog(16'h0040, 8'hA2); exp_mem[8'h40] = 8'hA2;
    prog(16'h007F, 8'hA3); exp_mem[8'h7F] = 8'hA3;
    prog(16'h0080, 8'hA4); exp_mem[8'h80] = 8'hA4;
    run_op(K_PE, 16'h0040);
    for (int i = 64; i < 128; i++) exp_mem[i] = 8'h00;
    rdflash(16'h003F, v); check(v == exp_mem[8'h3F], "R6 below page", {8'h0, v}, {8'h0, exp_mem[8'h3F]});
    rdflash(16'h0040, v); check(v == 8'h00, "R6 page start", {8'h0, v}, 16'h0);
    rdflash(16'h007F, v); check(v == 8'h00, "R6 page end", {8'h0, v}, 16'h0);
    rdflash(16'h0080, v); check(v == exp_mem[8'h80], "R6 above page", {8'h0, v}, {8'h0, exp_mem[8'h80]});

    // R7 misaligned page erase
    prog(16'h0041, 8'h77); exp_mem[8'h41] = 8'h77;
    run_op(K_PE, 16'h0041);
    rd(S_CT, v); check(v[6] == 1'b1, "R7 error set", {8'h0, v}, 16'h40);
    rdflash(16'h0041, v); check(v == 8'h77, "R7 byte kept", {8'h0, v}, 16'h77);
    rd(S_CT, v); check(v[6] == 1'b0, "R7 error cleared", {8'h0, v}, 16'h0);

    // R12 busy and second start ignored; R10 address write ignored
    prog(16'h0022, 8'h3C); exp_mem[8'h22] = 8'h3C;
    wr(S_WD, 8'hC3, 1'b1);
    set_addr(16'h0022);
    wr(S_CT, {5'b0, 1'b1, K_RD}, 1'b1);
    rd(S_CT, st); check(st[7] == 1'b1, "R12 busy after start", {8'h0, st}, 16'h80);
    wr(S_CT, {5'b0, 1'b1, K_PG}, 1'b1);
    wr(S_LO, 8'h33, 1'b1);
    wait_idle();
    rd(S_LO, v); check(v == 8'h22, "R10 addr held", {8'h0, v}, 16'h22);
    rd(S_RD, v); check(v == 8'h3C, "R5 read data", {8'h0, v}, 16'h3C);
    rdflash(16'h0022, v); check(v == 8'h3C, "R12 second start ignored", {8'h0, v}, 16'h3C);

    // R10 write-data write ignored while busy
    wr(S_WD, 8'h11, 1'b1);
    set_addr(16'h0030);
    wr(S_CT, {5'b0, 1'b1, K_PG}, 1'b1);
    wr(S_WD, 8'h99, 1'b1);
    wait_idle(); exp_mem[8'h30] = 8'h11;
    rdflash(16'h0030, v); check(v == 8'h11, "R10 wdata held", {8'h0, v}, 16'h11);

    // R11 user code cannot start operations
    prog(16'h0031, 8'h66); exp_mem[8'h31] = 8'h66;
    rdflash(16'h0030, v);
    set_addr(16'h0031);
    wr(S_CT, {5'b0, 1'b1, K_RD}, 1'b0);
    rd(S_CT, st); check(st[7] == 1'b0, "R11 no busy", {8'h0, st}, 16'h0);
    repeat (8) @(negedge clk);
    rd(S_RD, v); check(v == 8'h11, "R11 read data untouched", {8'h0, v}, 16'h11);

    // R9 option alias, R4 no change before reset, R3 boot from flash
    prog(16'h3FFF, 8'h01); exp_opt = 8'h01;
    rdflash(16'hFFFF, v); check(v == 8'h01, "R9 alias read", {8'h0, v}, 16'h01);
    run_op(K_PG, 16'hFFFF);
    rd(S_CT, v); check(v[6] == 1'b1, "R9 alias program refused", {8'h0, v}, 16'h40);
    check(run_boot_rom == 1'b1, "R4 boot held", {15'b0, run_boot_rom}, 16'h1);
    pin_reset();
    check_boot("R3");
    rd(S_LO, v); check(v == 8'h00, "R1 lo after pin reset", {8'h0, v}, 16'h0);
    rdflash(16'h0031, v); check(v == 8'h66, "R5 retained over reset", {8'h0, v}, 16'h66);

    // R8 mass erase clears option, R2 again via exit
    run_op(K_ME, 16'h0000); exp_opt = 8'h00;
    rdflash(16'hFFFF, v); check(v == 8'h00, "R8 option cleared", {8'h0, v}, 16'h0);
    rdflash(16'h0031, v); check(v == 8'h00, "R8 array cleared", {8'h0, v}, 16'h0);
    check(run_boot_rom == 1'b0, "R4 boot held after erase", {15'b0, run_boot_rom}, 16'h0);
    do_exit();
    check_boot("R2 after exit");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule